// File: doc/BRIEF.md
# Dual-Rail Tree Magnitude Comparator

This block compares two unsigned operands whose every bit travels on a pair of wires: one wire high carries a 1, the other high carries a 0, and both low is the empty spacer between operations. A leaf cell turns each pair of corresponding bits into a one-hot code of three wires: less, greater or equal. A balanced binary tree of merge cells folds neighbouring groups together. The depth of the result therefore grows with the logarithm of the width rather than with the width itself.

A merge cell favours its more significant child. When that child says less or greater, its verdict stands. When it says equal, the less significant child's verdict passes up. A merge cell stays empty until both of its children carry a code. This makes the root's output a completion indicator as well as a result. The `done` output is high exactly when the root holds a code. Between operations the producer returns every rail to zero, and the tree empties back to the spacer state.

A clock and a synchronous active-low reset are present only to sample the built-in checks. The data path is purely combinational and contains no state.

Top module: `drc_compare`

## Requirements
- R1: For every operand bit, the rail `*_t` high means 1, the rail `*_f` high means 0, and both low means spacer. Both rails high is illegal input.
- R2: Once every bit of both operands carries data and A > B (unsigned), `gt` is high and `lt`, `eq` are low.
- R3: Once every bit of both operands carries data and A < B (unsigned), `lt` is high and `gt`, `eq` are low.
- R4: Once every bit of both operands carries data and A == B, including all zeros and all ones, `eq` is high and `lt`, `gt` are low.
- R5: At no time is more than one of `lt`, `gt`, `eq` high.
- R6: `done` is high exactly when one of `lt`, `gt`, `eq` is high. It is high whenever every bit of both operands carries data.
- R7: While any bit pair of either operand is still spacer, all of `lt`, `gt`, `eq` and `done` are low. This holds for partially arrived operands and for the all-spacer state.
- R8: When the most significant bits differ, that bit alone sets the verdict, whatever the lower bits hold. For example, A=0x80 and B=0x7F give `gt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the built-in checks |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| a_t | input | WIDTH | Operand A, rails asserted for a 1 bit |
| a_f | input | WIDTH | Operand A, rails asserted for a 0 bit |
| b_t | input | WIDTH | Operand B, rails asserted for a 1 bit |
| b_f | input | WIDTH | Operand B, rails asserted for a 0 bit |
| lt | output | 1 | A is smaller than B |
| gt | output | 1 | A is greater than B |
| eq | output | 1 | A equals B |
| done | output | 1 | A valid verdict is present |

## Verification
Equal operands, including all zeros and all ones, force every merge cell to pass its lower child upward. This pattern shows whether the equal path is wired end to end. Operands that differ only in bit 0, or only in the top bit against opposite lower bits, separate a correct significance order from a reversed one. Operands where only A has arrived, or where A has arrived with one bit of B missing, show whether the tree wrongly completes before all the data is present. Random pairs with spacers between them cover the remaining mixes and confirm that the tree empties after every operation.

// File: rtl/drc_pkg.sv
// Shared types for the dual-rail comparator.
// Assumes: a code with no wire high is "empty"; at most one wire is ever high.
package drc_pkg;
    typedef struct packed {
        logic s;   // A side smaller
        logic g;   // A side greater
        logic e;   // sides equal
    } sge_t;

    localparam sge_t SGE_EMPTY = '{s: 1'b0, g: 1'b0, e: 1'b0};
    localparam sge_t SGE_EQUAL = '{s: 1'b0, g: 1'b0, e: 1'b1};

    // True when the code carries a verdict.
    function automatic logic sge_valid(input sge_t c);
        return c.s | c.g | c.e;
    endfunction
endpackage

// File: rtl/drc_bit_cell.sv
// Leaf cell: turns one dual-rail bit of A and of B into a one-hot verdict.
// Assumes: rails are legal (never both high); outputs empty while either pair is spacer.
module drc_bit_cell
    import drc_pkg::*;
(
    input  logic a_t,
    input  logic a_f,
    input  logic b_t,
    input  logic b_f,
    output sge_t code
);
    // Each output term needs one rail from each operand, so spacer gives empty.
    always_comb begin
        code.g = a_t & b_f;
        code.s = a_f & b_t;
        code.e = (a_t & b_t) | (a_f & b_f);
    end
endmodule

// File: rtl/drc_merge_cell.sv
// Merge cell: combines a more significant group verdict with a less significant one.
// Assumes: both inputs are one-hot or empty; output empty until both inputs are valid.
module drc_merge_cell
    import drc_pkg::*;
(
    input  sge_t hi,
    input  sge_t lo,
    output sge_t res
);
    logic lo_ok;

    // Completion of the lower group gates the upper group's decisive verdict.
    always_comb begin
        lo_ok = sge_valid(lo);
        res.g = (hi.g & lo_ok) | (hi.e & lo.g);
        res.s = (hi.s & lo_ok) | (hi.e & lo.s);
        res.e = hi.e & lo.e;
    end
endmodule

// File: rtl/drc_tree.sv
// Balanced comparison tree over WIDTH dual-rail bit pairs.
// Nodes are stored heap-style: node i has children 2i+1 (more significant) and 2i+2.
// Assumes: widths that are not a power of two are padded above the MSB with constant
// "equal" leaves, which pass the lower verdict through unchanged.
module drc_tree
    import drc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] a_f,
    input  logic [WIDTH-1:0] b_t,
    input  logic [WIDTH-1:0] b_f,
    output sge_t             root
);
    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    sge_t node [NODES];

    // Leaves: bit k sits at heap slot 2*LEAVES-2-k, so the left child is more significant.
    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        localparam int SLOT = 2 * LEAVES - 2 - k;
        if (k < WIDTH) begin : g_real
            drc_bit_cell u_bit (
                .a_t  (a_t[k]),
                .a_f  (a_f[k]),
                .b_t  (b_t[k]),
                .b_f  (b_f[k]),
                .code (node[SLOT])
            );
        end else begin : g_pad
            assign node[SLOT] = SGE_EQUAL;
        end
    end

    // Internal merge cells, one per heap slot above the leaves.
    for (genvar i = 0; i < LEAVES - 1; i++) begin : g_merge
        drc_merge_cell u_mrg (
            .hi  (node[2*i+1]),
            .lo  (node[2*i+2]),
            .res (node[i])
        );
    end

    assign root = node[0];
endmodule

// File: rtl/drc_compare.sv
// Top: dual-rail unsigned magnitude comparator with code-derived completion.
// The data path is combinational; clk/rst_n only sample the checks below.
// Assumes: the producer returns all rails to zero between operations.
module drc_compare
    import drc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] a_f,
    input  logic [WIDTH-1:0] b_t,
    input  logic [WIDTH-1:0] b_f,
    output logic             lt,
    output logic             gt,
    output logic             eq,
    output logic             done
);
    sge_t verdict;

    drc_tree #(.WIDTH(WIDTH)) u_tree (
        .a_t  (a_t),
        .a_f  (a_f),
        .b_t  (b_t),
        .b_f  (b_f),
        .root (verdict)
    );

    // Drive the verdict wires and the completion flag from the root code.
    always_comb begin
        lt   = verdict.s;
        gt   = verdict.g;
        eq   = verdict.e;
        done = sge_valid(verdict);
    end

    // Checks: input legality, output encoding, completion and spacer behaviour.
    AST_RAIL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_t & a_f) == '0) && ((b_t & b_f) == '0));                          // R1
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lt, gt, eq}));                                               // R5
    AST_ALL_DATA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (((a_t ^ a_f) == '1) && ((b_t ^ b_f) == '1)) |-> done);                // R6
    AST_MISSING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (((a_t | a_f) != '1) || ((b_t | b_f) != '1)) |-> !(lt || gt || eq));   // R7
    AST_SAME_IS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (((a_t ^ a_f) == '1) && ((b_t ^ b_f) == '1) && (a_t == b_t)) |-> eq);  // R4
endmodule

// File: tb/drc_compare_bench.sv
module drc_compare_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
    logic lt, gt, eq, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit seen = 1'b0;
    logic [2:0] expq [$];   // expected {lt,gt,eq}

    always #2 clk = ~clk;   // 250 MHz

    drc_compare #(.WIDTH(W)) u_drc_compare (
        .clk(clk), .rst_n(rst_n),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .lt(lt), .gt(gt), .eq(eq), .done(done)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {lt,gt,eq,done} got %b expected %b", req, act, exp);
        end
    endtask

    task automatic to_spacer();
        @(posedge clk); #1;
        a_t = '0; a_f = '0; b_t = '0; b_f = '0;
        @(negedge clk);
        check("R7 spacer", {lt, gt, eq, done}, 4'b0000);
    endtask

    // Driver: spacer, A only, A with one B bit missing, then full B; expected value queued.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] hole;
        to_spacer();
        @(posedge clk); #1;
        a_t = a; a_f = ~a;
        @(negedge clk);
        check("R7 only A", {lt, gt, eq, done}, 4'b0000);
        hole = W'(1) << ($urandom % W);
        @(posedge clk); #1;
        b_t = b & ~hole; b_f = ~b & ~hole;
        @(negedge clk);
        check("R7 B bit missing", {lt, gt, eq, done}, 4'b0000);
        expq.push_back({a < b, a > b, a == b});
        @(posedge clk); #1;
        b_t = b; b_f = ~b;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: on each new completion pop the expected verdict and compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && !seen) begin
                seen = 1'b1;
                if (expq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6: done with no pending operation, got %b expected none",
                             {lt, gt, eq});
                end else begin
                    logic [2:0] e;
                    e = expq.pop_front();
                    check(e[1] ? "R2 gt" : (e[2] ? "R3 lt" : "R4 eq"),
                          {lt, gt, eq, done}, {e, 1'b1});
                    check("R5 one-hot", {3'b000, $onehot({lt, gt, eq})}, 4'b0001);
                end
            end else if (!done) begin
                seen = 1'b0;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset idle", {lt, gt, eq, done}, 4'b0000);

        // R1/R4: equal operands at the extremes and middle.
        apply(8'h00, 8'h00);
        apply(8'hFF, 8'hFF);
        apply(8'h5A, 8'h5A);
        // R2/R3: differ only in bit 0.
        apply(8'h01, 8'h00);
        apply(8'h00, 8'h01);
        // R8: MSB decides against opposite lower bits.
        apply(8'h80, 8'h7F);
        apply(8'h7F, 8'h80);
        apply(8'hFF, 8'h00);
        // Random pairs, some forced equal.
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (i % 5 == 0) ? ra : W'($urandom);
            apply(ra, rb);
        end
        to_spacer();
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R6: %0d results never completed, expected 0", expq.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule